// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a logic array that can be reprogrammed at run time. Each primary input supplies two literals to a programmable AND plane: the input as it is, and its inverse. Every product term is the AND of whichever literals its configuration selects. A second programmable plane then ORs a selected set of product terms onto each output. A product term can feed any number of outputs, so two functions that have a term in common use one AND gate between them. With the default sizing of 16 inputs, 32 product terms and 8 outputs, a single array can hold several related functions in sum-of-products form.

The configuration of both planes is one serial chain. While the load enable is high, one bit enters the chain on each clock. The bit that drops off the far end appears on a serial output, so arrays can be cascaded and an old configuration can be read back while a new one is shifted in. When the load enable is low, the array evaluates the inputs through its combinational planes, and a synchronous output register samples the result.

Top module: `sop_array`

## Requirements
- R1: A synchronous reset clears every configuration bit, the output register and `cfg_out`. Until a configuration is loaded, every output reads 0 for any input pattern.
- R2: While `cfg_en` is high, the chain moves one position per rising clock edge. The bit that enters at `cfg_in` first ends up at chain index 0. After a full-length load, chain index k holds the k-th bit that was shifted in. `cfg_out` always shows chain index 0, so it presents the earlier contents in the same order in which they were loaded.
- R3: With 2*N_IN literals per term, literal 2i is input i and literal 2i+1 is the inverse of input i. The AND-plane bit for term t and literal l sits at chain index t*2*N_IN + l.
- R4: A product term whose mask selects no literal evaluates to 0, not to 1.
- R5: The OR-plane bit that connects term p to output o sits at chain index N_TERM*2*N_IN + o*N_TERM + p. One term can drive several outputs at the same time.
- R6: The output register samples the sum-of-products value at each rising edge while `cfg_en` is low. A change at `x_in` therefore reaches `f_out` one clock later.
- R7: At every clock edge where `cfg_en` is high, the output register loads 0. After `cfg_en` falls, the outputs become valid at the next edge.
- R8: While `cfg_en` is low, the configuration does not change, whatever `cfg_in` does.
- R9: An output whose OR-plane row selects no term reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Load enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (chain index 0) |
| x_in | input | N_IN | Logic inputs |
| f_out | output | N_OUT | Registered sum-of-products outputs |

## Verification
The bench builds the array with 3 inputs, 4 product terms and 2 outputs. This gives a 32-bit chain, so a whole configuration fits in one word and all eight input patterns can be swept after every load. It loads a configuration with two outputs that share terms, a configuration that uses an empty term and an empty OR row, a configuration that places single literals to pin down literal order, and a series of pseudo-random configurations. It compares every output pattern against a sum-of-products value computed from the configuration word. Each load also reads back the previous configuration on `cfg_out`, so chain order and cascading are checked bit by bit.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Chain position of the AND-plane bit for term t, literal l.
  function automatic int unsigned and_bit_idx(input int unsigned t,
                                              input int unsigned l,
                                              input int unsigned n_lit);
    return t * n_lit + l;
  endfunction

  // Chain position of the OR-plane bit for output o, term p.
  function automatic int unsigned or_bit_idx(input int unsigned o,
                                             input int unsigned p,
                                             input int unsigned n_term,
                                             input int unsigned and_bits);
    return and_bits + o * n_term + p;
  endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int LEN = 1280
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] bits,
  output logic           dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else if (shift_en) begin
      bits <= {din, bits[LEN-1:1]};
    end
  end

  assign dout = bits[0];

  // R8: the chain holds its contents while loading is off
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(bits));

  // R2: a shifted bit enters at the head, and the tail moves one step
  p_shift_head_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> bits[LEN-1] == $past(din));

  p_shift_tail_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> dout == $past(bits[1]));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN   = 16,
  parameter int N_TERM = 32
) (
  input  logic [N_IN-1:0]          x,
  input  logic [N_TERM*2*N_IN-1:0] mask,
  output logic [N_TERM-1:0]        term
);

  localparam int N_LIT = 2 * N_IN;

  logic [N_LIT-1:0] lits;

  // Literal 2i is the input, literal 2i+1 is its inverse.
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = x[i];
    assign lits[2*i+1] = ~x[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_LIT-1:0] m;
    assign m = mask[t*N_LIT +: N_LIT];
    // An empty mask gives 0, so an unused term stays off.
    assign term[t] = (|m) & (&(lits | ~m));
  end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 32,
  parameter int N_OUT  = 8
) (
  input  logic [N_TERM-1:0]       term,
  input  logic [N_OUT*N_TERM-1:0] sel,
  output logic [N_OUT-1:0]        sum
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign sum[o] = |(term & sel[o*N_TERM +: N_TERM]);
  end

endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 32,
  parameter int N_OUT  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_in,
  output logic             cfg_out,
  input  logic [N_IN-1:0]  x_in,
  output logic [N_OUT-1:0] f_out
);

  localparam int N_LIT    = 2 * N_IN;
  localparam int AND_BITS = N_TERM * N_LIT;
  localparam int OR_BITS  = N_OUT * N_TERM;
  localparam int CFG_LEN  = AND_BITS + OR_BITS;

  logic [CFG_LEN-1:0] cfg_bits;
  logic [N_TERM-1:0]  terms;
  logic [N_OUT-1:0]   sums;

  sop_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .din      (cfg_in),
    .bits     (cfg_bits),
    .dout     (cfg_out)
  );

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .x    (x_in),
    .mask (cfg_bits[AND_BITS-1:0]),
    .term (terms)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term (terms),
    .sel  (cfg_bits[CFG_LEN-1:AND_BITS]),
    .sum  (sums)
  );

  // Output register: cleared during loading, sampled otherwise.
  always_ff @(posedge clk) begin
    if (rst || cfg_en) begin
      f_out <= '0;
    end else begin
      f_out <= sums;
    end
  end

  // R1: reset leaves outputs and serial out at 0
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (f_out == '0 && cfg_out == 1'b0));

  // R7: a load cycle leaves the outputs at 0
  p_quiet_load_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> f_out == '0);

  // R6: with inputs and configuration steady, the registered output is steady
  p_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !$past(cfg_en) && $stable(x_in) && !$past(rst)) |=> $stable(f_out));

  for (genvar t = 0; t < N_TERM; t++) begin : g_chk_term
    // R4: a term with no literal never fires
    p_empty_term_r4: assert property (@(posedge clk) disable iff (rst)
      (cfg_bits[and_bit_idx(t, 0, N_LIT) +: N_LIT] == '0) |-> !terms[t]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk_out
    // R9: an empty OR row gives 0
    p_empty_row_r9: assert property (@(posedge clk) disable iff (rst)
      (cfg_bits[or_bit_idx(o, 0, N_TERM, AND_BITS) +: N_TERM] == '0) |-> !sums[o]);
  end

endmodule

// File: tb/sim_sop_array.sv
module sim_sop_array;

  localparam int NI  = 3;
  localparam int NT  = 4;
  localparam int NO  = 2;
  localparam int NL  = 2 * NI;
  localparam int AB  = NT * NL;
  localparam int LEN = AB + NO * NT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic          cfg_in = 1'b0;
  logic          cfg_out;
  logic [NI-1:0] x_in = '0;
  logic [NO-1:0] f_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sop_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .x_in(x_in), .f_out(f_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LEN-1:0] set_and(input logic [LEN-1:0] c, input int t, input int l);
    c[t*NL + l] = 1'b1;
    return c;
  endfunction

  function automatic logic [LEN-1:0] set_or(input logic [LEN-1:0] c, input int o, input int p);
    c[AB + o*NT + p] = 1'b1;
    return c;
  endfunction

  // Sum-of-products value taken from the chain layout given in R3 and R5.
  function automatic logic [NO-1:0] model(input logic [LEN-1:0] c, input logic [NI-1:0] x);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++) begin
      for (int p = 0; p < NT; p++) begin
        bit any = 0;
        bit val = 1;
        for (int l = 0; l < NL; l++) begin
          if (c[p*NL + l]) begin
            any = 1;
            if ((l % 2) == 1) val = val & ~x[l/2];
            else              val = val & x[l/2];
          end
        end
        if (c[AB + o*NT + p] && any && val) r[o] = 1'b1;
      end
    end
    return r;
  endfunction

  logic [LEN-1:0] cur_cfg = '0;

  // Shift in a new configuration and check the read-back of the old one.
  task automatic load(input logic [LEN-1:0] c);
    logic [LEN-1:0] old;
    for (int k = 0; k < LEN; k++) begin
      @(negedge clk);
      old[k] = cfg_out;
      if (k == 2) chk("R7 outputs zero during load", 32'(f_out), 32'h0);
      cfg_in = c[k];
      cfg_en = 1'b1;
    end
    @(negedge clk);
    chk("R7 outputs zero at end of load", 32'(f_out), 32'h0);
    chk("R2 read-back of previous chain", 32'(old), 32'(cur_cfg));
    cfg_en = 1'b0;
    cfg_in = 1'b0;
    cur_cfg = c;
  endtask

  // Sweep all inputs; cfg_in toggles to show it is ignored (R8).
  task automatic sweep(input string req);
    for (int v = 0; v < (1 << NI); v++) begin
      x_in = NI'(v);
      cfg_in = v[0];
      if (v > 0) begin
        #1;
        chk("R6 output one cycle behind input", 32'(f_out), 32'(model(cur_cfg, NI'(v-1))));
      end
      @(negedge clk);
      chk(req, 32'(f_out), 32'(model(cur_cfg, NI'(v))));
    end
    cfg_in = 1'b0;
  endtask

  initial begin
    logic [LEN-1:0] c;
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset f_out", 32'(f_out), 32'h0);
    chk("R1 reset cfg_out", 32'(cfg_out), 32'h0);
    sweep("R1 unconfigured outputs zero");

    // Two outputs sharing terms 0 and 2 (R5).
    c = '0;
    c = set_and(c, 0, 0); c = set_and(c, 0, 2);                      // x0 x1
    c = set_and(c, 1, 0); c = set_and(c, 1, 5);                      // x0 ~x2
    c = set_and(c, 2, 1); c = set_and(c, 2, 3); c = set_and(c, 2, 4); // ~x0 ~x1 x2
    c = set_and(c, 3, 0); c = set_and(c, 3, 4);                      // x0 x2
    c = set_or(c, 0, 0); c = set_or(c, 0, 1); c = set_or(c, 0, 2);
    c = set_or(c, 1, 0); c = set_or(c, 1, 2); c = set_or(c, 1, 3);
    load(c);
    sweep("R5 shared product terms");
    x_in = 3'b011; @(negedge clk);
    chk("R5 shared term x0x1 on both outputs", 32'(f_out), 32'h3);

    // Empty term 0 on both outputs, empty row none; term 1 = ~x1 (R4).
    c = '0;
    c = set_and(c, 1, 3);
    c = set_or(c, 0, 0);
    c = set_or(c, 1, 0); c = set_or(c, 1, 1);
    load(c);
    sweep("R4 empty term reads 0");
    x_in = 3'b000; @(negedge clk);
    chk("R4 output fed by empty term only", 32'(f_out), 32'h2);

    // Single literals to fix the literal order (R3); output 0 row empty (R9).
    c = '0;
    c = set_and(c, 0, 0); c = set_and(c, 1, 1);
    c = set_and(c, 2, 4); c = set_and(c, 3, 3);
    c = set_or(c, 1, 2); c = set_or(c, 1, 3);
    load(c);
    sweep("R3 literal order");
    x_in = 3'b010; @(negedge clk);
    chk("R9 empty row output 0, R3 x2|~x1 false", 32'(f_out), 32'h0);
    x_in = 3'b100; @(negedge clk);
    chk("R3 x2 literal drives output 1", 32'(f_out), 32'h2);

    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 8; n++) begin
      for (int s = 0; s < 32; s++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      load(LEN'(lfsr));
      sweep("R5 random configuration");
    end

    load('0);
    sweep("R9 cleared configuration outputs zero");

    x_in = 3'b111;
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R1 reset clears outputs", 32'(f_out), 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule